// File: doc/BRIEF.md
# Grouped GPIO pad register bank

This block holds the configuration of a set of general-purpose I/O pads. It presents them to software as 32-bit registers on a simple read/write bus, drives each pad's output enable and output level, and samples the pad inputs. Pads are arranged in groups of up to fifteen slots. How many slots of each group are actually fitted is fixed per group by a parameter. Pin number p lives in group p/15, slot p%15.

Each fitted pad owns two configuration words. The first word holds the pad mode, the output level, the interrupt line the pad is routed to, and a read-only view of the synchronised input. The second word holds the edge/level trigger selection and a four-bit inversion field. The interrupt-related fields are only stored here and passed out as flat vectors to a separate interrupt block. Any access that does not land on a fitted pad reads zero, changes nothing and raises an error flag.

Top module: `gpio_pad_bank`

## Requirements
- R1: Addresses are byte addresses on a 16-bit bus. The first word of group g, slot s sits at 0x4400 + 0x400*g + 8*s, and the second word sits 4 bytes above it. A write to either word is read back from the same address.
- R2: An access is in error when the address is below 0x4400, is not a multiple of 4, has a group index at or above NUM_GROUPS, or has a slot at or above 15 or at or above that group's fitted count. While bus_en is high such an access gives bus_err=1 and bus_rdata=0. bus_err is 0 whenever bus_en is low.
- R3: A write that is in error changes no pad state and no pad output. In particular, a slot-15 address never aliases onto the next group's slot 0.
- R4: In the first word, bit 1 is the output level, bits 10:8 are the mode, and bits 31:28 are the interrupt line. Bit 0 is read-only. All other bits read 0 and ignore writes.
- R5: In the second word, bits 2:0 are the trigger selection and bits 7:4 are the inversion field. All other bits read 0.
- R6: After reset every pad has mode 3 and all other fields at 0. The first word reads 0x00000300, and all pad_oe, pad_out, pad_irq_sel and pad_irq_trig bits are 0.
- R7: pad_oe of a fitted pad is 1 only in mode 0 (bidirectional) or mode 1 (output only). Modes 2 (input only), 3 (high impedance) and 4 to 7 hold it at 0 whatever the output level bit holds.
- R8: pad_out of a fitted pad equals its output level bit. pad_oe and pad_out of an unfitted slot are always 0.
- R9: Bit 0 of the first word shows pad_in after two flip-flop stages, so a change on pad_in made after clock edge k is read back after edge k+2. Bit 0 reads 0 in modes other than 0 and 2.
- R10: When bit 6 of the second word is set (inversion field value 0x4), bit 0 of the first word shows the inverted synchronised input. The other inversion bits do not change bit 0.
- R11: pad_irq_sel[4p+3:4p] carries bits 31:28 of pad p's first word, and pad_irq_trig[3p+2:3p] carries bits 2:0 of its second word. Both are 0 for unfitted slots.
- R12: Reads are combinational and valid in the same cycle as bus_en. A write is captured at the clock edge where bus_en and bus_we are high, and the pad outputs reflect it right after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_en | input | 1 | Access strobe for the current cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| bus_err | output | 1 | Access does not decode to a fitted pad |
| pad_in | input | NUM_GROUPS*15 | Raw pad input levels, index p = 15*g + s |
| pad_oe | output | NUM_GROUPS*15 | Pad output enable |
| pad_out | output | NUM_GROUPS*15 | Pad output level |
| pad_irq_sel | output | 4*NUM_GROUPS*15 | Interrupt line number per pad |
| pad_irq_trig | output | 3*NUM_GROUPS*15 | Trigger selection per pad |

## Verification
Each result of this block is due at a different time. Read data and the error flag are due in the very cycle the access is presented, so the bench checks them 1 ns after it drives the address, with no clock edge in between. Pad outputs and exported fields follow a write from the edge that captures it; a reference model updated just after that edge is compared against them at every falling edge. An input change is due on bit 0 two rising edges after it is applied, and the bench keeps a history queue of pad_in sampled at each edge so that the expected value is the entry one before the newest.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int ADDR_W          = 16;
  localparam int SLOTS_PER_GROUP = 15;
  localparam logic [ADDR_W-1:0] PAD_BASE = 16'h4400;

  localparam logic [2:0] MODE_BIDIR = 3'd0;
  localparam logic [2:0] MODE_OUT   = 3'd1;
  localparam logic [2:0] MODE_IN    = 3'd2;
  localparam logic [2:0] MODE_HIZ   = 3'd3;

  // bit of the inversion field that flips the received level (word 1 bit 6)
  localparam int RX_INV_BIT = 2;

  typedef struct packed {
    logic       in_window;
    logic [5:0] group;
    logic [6:0] slot;
    logic       word1;
  } pad_addr_t;

  // Split a byte address into group, slot and word select.
  function automatic pad_addr_t split_addr(input logic [ADDR_W-1:0] a);
    logic [ADDR_W-1:0] off;
    pad_addr_t         r;
    off         = a - PAD_BASE;
    r.in_window = (a >= PAD_BASE) && (off[1:0] == 2'b00);
    r.group     = off[15:10];
    r.slot      = off[9:3];
    r.word1     = off[2];
    return r;
  endfunction

  function automatic logic mode_drives(input logic [2:0] m);
    return (m == MODE_BIDIR) || (m == MODE_OUT);
  endfunction

  function automatic logic mode_senses(input logic [2:0] m);
    return (m == MODE_BIDIR) || (m == MODE_IN);
  endfunction

  function automatic logic [31:0] pack_word0(input logic [3:0] irq, input logic [2:0] mode,
                                             input logic tx, input logic rx);
    return {irq, 17'd0, mode, 6'd0, tx, rx};
  endfunction

  function automatic logic [31:0] pack_word1(input logic [3:0] inv, input logic [2:0] trig);
    return {24'd0, inv, 1'b0, trig};
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int WIDTH = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [WIDTH-1:0] meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= '0;
      q      <= '0;
    end else begin
      meta_q <= d;
      q      <= meta_q;
    end
  end

endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_bank_pkg::*;
#(
  parameter int                      NUM_GROUPS = 4,
  parameter logic [4*NUM_GROUPS-1:0] GROUP_POP  = 16'hC8F9,
  localparam int NPADS = NUM_GROUPS * SLOTS_PER_GROUP,
  localparam int IDX_W = $clog2(NPADS)
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [IDX_W-1:0]  pad_idx,
  output logic              sel_w1
);

  pad_addr_t  fa;
  logic [3:0] pop;
  logic       grp_ok;

  always_comb begin
    fa     = split_addr(addr);
    grp_ok = int'(fa.group) < NUM_GROUPS;
    pop    = '0;
    for (int g = 0; g < NUM_GROUPS; g++) begin
      if (int'(fa.group) == g) pop = GROUP_POP[4*g +: 4];
    end
    hit     = fa.in_window && grp_ok &&
              (fa.slot < 7'(SLOTS_PER_GROUP)) && (fa.slot < {3'b000, pop});
    pad_idx = IDX_W'(int'(fa.group) * SLOTS_PER_GROUP + int'(fa.slot));
    sel_w1  = fa.word1;
  end

endmodule

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell
  import gpio_bank_pkg::*;
#(
  parameter bit POPULATED = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_w0,
  input  logic        wr_w1,
  input  logic [31:0] wdata,
  input  logic        rx_sync,
  output logic [31:0] word0,
  output logic [31:0] word1,
  output logic        oe,
  output logic        out,
  output logic [3:0]  irq_sel,
  output logic [2:0]  trig
);

  logic [2:0] mode_q;
  logic       tx_q;
  logic [3:0] irq_q;
  logic [3:0] inv_q;
  logic [2:0] trig_q;
  logic       rx_bit;
  logic       unused_wdata;

  assign unused_wdata = ^{wdata[27:11], wdata[3], wdata[0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= MODE_HIZ;
      tx_q   <= 1'b0;
      irq_q  <= '0;
      inv_q  <= '0;
      trig_q <= '0;
    end else begin
      if (wr_w0) begin
        tx_q   <= wdata[1];
        mode_q <= wdata[10:8];
        irq_q  <= wdata[31:28];
      end
      if (wr_w1) begin
        inv_q  <= wdata[7:4];
        trig_q <= wdata[2:0];
      end
    end
  end

  assign rx_bit  = mode_senses(mode_q) & (rx_sync ^ inv_q[RX_INV_BIT]);
  assign word0   = POPULATED ? pack_word0(irq_q, mode_q, tx_q, rx_bit) : '0;
  assign word1   = POPULATED ? pack_word1(inv_q, trig_q) : '0;
  assign oe      = POPULATED && mode_drives(mode_q);
  assign out     = POPULATED && tx_q;
  assign irq_sel = POPULATED ? irq_q : '0;
  assign trig    = POPULATED ? trig_q : '0;

endmodule

// File: rtl/gpio_pad_bank.sv
module gpio_pad_bank
  import gpio_bank_pkg::*;
#(
  parameter int                      NUM_GROUPS = 4,
  parameter logic [4*NUM_GROUPS-1:0] GROUP_POP  = 16'hC8F9,
  localparam int NPADS = NUM_GROUPS * SLOTS_PER_GROUP,
  localparam int IDX_W = $clog2(NPADS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 bus_en,
  input  logic                 bus_we,
  input  logic [ADDR_W-1:0]    bus_addr,
  input  logic [31:0]          bus_wdata,
  output logic [31:0]          bus_rdata,
  output logic                 bus_err,
  input  logic [NPADS-1:0]     pad_in,
  output logic [NPADS-1:0]     pad_oe,
  output logic [NPADS-1:0]     pad_out,
  output logic [4*NPADS-1:0]   pad_irq_sel,
  output logic [3*NPADS-1:0]   pad_irq_trig
);

  // named internal events, observed by the bound checker
  logic [NPADS-1:0] rx_sync;
  logic             dec_hit;
  logic [IDX_W-1:0] dec_idx;
  logic             dec_w1;
  logic             wr_req;

  logic [31:0] w0_arr [NPADS];
  logic [31:0] w1_arr [NPADS];

  gpio_addr_decode #(
    .NUM_GROUPS(NUM_GROUPS),
    .GROUP_POP (GROUP_POP)
  ) u_dec (
    .addr   (bus_addr),
    .hit    (dec_hit),
    .pad_idx(dec_idx),
    .sel_w1 (dec_w1)
  );

  gpio_in_sync #(.WIDTH(NPADS)) u_sync (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (pad_in),
    .q    (rx_sync)
  );

  assign wr_req = bus_en & bus_we & dec_hit;

  for (genvar p = 0; p < NPADS; p++) begin : g_pad
    localparam int GRP = p / SLOTS_PER_GROUP;
    localparam int SLT = p % SLOTS_PER_GROUP;
    localparam bit FIT = SLT < int'(GROUP_POP[4*GRP +: 4]);

    logic sel;
    assign sel = wr_req && (dec_idx == IDX_W'(p));

    gpio_pad_cell #(.POPULATED(FIT)) u_cell (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_w0  (sel && !dec_w1),
      .wr_w1  (sel && dec_w1),
      .wdata  (bus_wdata),
      .rx_sync(rx_sync[p]),
      .word0  (w0_arr[p]),
      .word1  (w1_arr[p]),
      .oe     (pad_oe[p]),
      .out    (pad_out[p]),
      .irq_sel(pad_irq_sel[4*p +: 4]),
      .trig   (pad_irq_trig[3*p +: 3])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_en && dec_hit) begin
      bus_rdata = dec_w1 ? w1_arr[dec_idx] : w0_arr[dec_idx];
    end
  end

  assign bus_err = bus_en & ~dec_hit;

endmodule

// File: rtl/gpio_pad_bank_chk.sv
module gpio_pad_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int                      NUM_GROUPS = 4,
  parameter logic [4*NUM_GROUPS-1:0] GROUP_POP  = 16'hC8F9,
  localparam int NPADS = NUM_GROUPS * SLOTS_PER_GROUP,
  localparam int IDX_W = $clog2(NPADS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               bus_en,
  input logic               bus_we,
  input logic [31:0]        bus_wdata,
  input logic [31:0]        bus_rdata,
  input logic               bus_err,
  input logic [NPADS-1:0]   pad_in,
  input logic [NPADS-1:0]   pad_oe,
  input logic [NPADS-1:0]   pad_out,
  input logic [4*NPADS-1:0] pad_irq_sel,
  input logic [3*NPADS-1:0] pad_irq_trig,
  input logic [NPADS-1:0]   rx_sync,
  input logic               dec_hit,
  input logic [IDX_W-1:0]   dec_idx,
  input logic               dec_w1
);

  function automatic logic [NPADS-1:0] fit_mask();
    logic [NPADS-1:0] m;
    for (int p = 0; p < NPADS; p++) begin
      m[p] = (p % SLOTS_PER_GROUP) < int'(GROUP_POP[4*(p / SLOTS_PER_GROUP) +: 4]);
    end
    return m;
  endfunction

  localparam logic [NPADS-1:0] FIT_MASK = fit_mask();

  logic [1:0] cyc_q;
  logic       unused_chk;
  logic       w0_write;

  assign unused_chk = ^{bus_wdata[31:11], bus_wdata[7:2], bus_wdata[0]};
  assign w0_write   = bus_en && bus_we && dec_hit && !dec_w1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cyc_q <= '0;
    else if (cyc_q != 2'd3)  cyc_q <= cyc_q + 2'd1;
  end

  AST_ERR_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_err |-> (bus_en && bus_rdata == '0)); // R2

  AST_ERR_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_err) |=> ($stable(pad_oe) && $stable(pad_out) &&
                                       $stable(pad_irq_sel) && $stable(pad_irq_trig))); // R3

  AST_W0_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && dec_hit && !dec_w1) |-> (bus_rdata[27:11] == '0 && bus_rdata[7:2] == '0)); // R4

  AST_W1_RESERVED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && dec_hit && dec_w1) |-> (bus_rdata[31:8] == '0 && !bus_rdata[3])); // R5

  AST_NO_OE_WHEN_NOT_DRIVING: assert property (@(posedge clk) disable iff (!rst_n)
    (w0_write && bus_wdata[10:8] >= 3'd2) |=> !pad_oe[$past(dec_idx)]); // R7

  AST_UNFIT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    ((pad_oe | pad_out) & ~FIT_MASK) == '0); // R8

  AST_SYNC_TWO_EDGES: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_q >= 2'd2) |-> (rx_sync == $past(pad_in, 2))); // R9

  AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    w0_write |=> (pad_out[$past(dec_idx)] == $past(bus_wdata[1]))); // R12

endmodule

bind gpio_pad_bank gpio_pad_bank_chk #(
  .NUM_GROUPS(NUM_GROUPS),
  .GROUP_POP (GROUP_POP)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .bus_en      (bus_en),
  .bus_we      (bus_we),
  .bus_wdata   (bus_wdata),
  .bus_rdata   (bus_rdata),
  .bus_err     (bus_err),
  .pad_in      (pad_in),
  .pad_oe      (pad_oe),
  .pad_out     (pad_out),
  .pad_irq_sel (pad_irq_sel),
  .pad_irq_trig(pad_irq_trig),
  .rx_sync     (rx_sync),
  .dec_hit     (dec_hit),
  .dec_idx     (dec_idx),
  .dec_w1      (dec_w1)
);

// File: tb/gpio_pad_bank_tb.sv
`timescale 1ns/1ps
module gpio_pad_bank_tb;

  localparam int NG = 4;
  localparam int NP = 60;
  localparam int POPS [4] = '{9, 15, 8, 12};

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              bus_en, bus_we;
  logic [15:0]       bus_addr;
  logic [31:0]       bus_wdata, bus_rdata;
  logic              bus_err;
  logic [NP-1:0]     pad_in, pad_oe, pad_out;
  logic [4*NP-1:0]   pad_irq_sel;
  logic [3*NP-1:0]   pad_irq_trig;

  always #2.5 clk = ~clk;

  gpio_pad_bank u_dut (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .pad_in(pad_in), .pad_oe(pad_oe), .pad_out(pad_out),
    .pad_irq_sel(pad_irq_sel), .pad_irq_trig(pad_irq_trig)
  );

  int  checks = 0;
  int  failures = 0;
  bit  done = 0;

  // reference model
  int m_mode [NP];
  int m_tx   [NP];
  int m_irq  [NP];
  int m_inv  [NP];
  int m_trig [NP];
  logic [NP-1:0] hist [$];

  function automatic bit fitted(int p);
    return (p % 15) < POPS[p / 15];
  endfunction

  function automatic int pad_addr(int g, int s, int w);
    return 'h4400 + g * 1024 + s * 8 + w * 4;
  endfunction

  function automatic void model_reset();
    for (int p = 0; p < NP; p++) begin
      m_mode[p] = 3; m_tx[p] = 0; m_irq[p] = 0; m_inv[p] = 0; m_trig[p] = 0;
    end
  endfunction

  function automatic logic [NP-1:0] exp_rx();
    if (hist.size() >= 2) return hist[hist.size() - 2];
    return '0;
  endfunction

  function automatic void exp_access(input int addr, output bit ok, output int p, output bit w1);
    int off, g, r, s;
    ok = 0; p = 0; w1 = 0;
    if (addr < 'h4400 || addr > 'hFFFF || (addr % 4) != 0) return;
    off = addr - 'h4400;
    g = off / 1024; r = off % 1024; s = r / 8; w1 = (r % 8) == 4;
    if (g >= NG || s >= 15 || s >= POPS[g]) return;
    ok = 1; p = g * 15 + s;
  endfunction

  function automatic logic [31:0] exp_word(int p, bit w1);
    logic [NP-1:0] rx;
    logic rb;
    rx = exp_rx();
    if (w1) return (32'(m_inv[p]) << 4) | 32'(m_trig[p]);
    rb = (m_mode[p] == 0 || m_mode[p] == 2) ? (rx[p] ^ m_inv[p][2]) : 1'b0;
    return (32'(m_irq[p]) << 28) | (32'(m_mode[p]) << 8) | (32'(m_tx[p]) << 1) | 32'(rb);
  endfunction

  task automatic check(input bit ok, input string tag, input logic [255:0] act, input logic [255:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd(input int addr, input string tag, output logic [31:0] got);
    bit ok; int p; bit w1; logic [31:0] e;
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = addr[15:0];
    #1;
    exp_access(addr, ok, p, w1);
    e = ok ? exp_word(p, w1) : 32'd0;
    check(bus_err === !ok, {tag, " (R2 err flag)"}, 256'(bus_err), 256'(!ok));
    check(bus_rdata === e, tag, 256'(bus_rdata), 256'(e));
    got = bus_rdata;
    #1 bus_en = 1'b0;
  endtask

  task automatic wr(input int addr, input logic [31:0] d);
    bit ok; int p; bit w1;
    @(posedge clk); #1;
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = addr[15:0]; bus_wdata = d;
    @(posedge clk); #1;
    bus_en = 1'b0; bus_we = 1'b0;
    exp_access(addr, ok, p, w1);
    if (ok) begin
      if (w1) begin
        m_inv[p] = int'((d >> 4) & 32'hF); m_trig[p] = int'(d & 32'h7);
      end else begin
        m_tx[p] = int'((d >> 1) & 32'h1); m_mode[p] = int'((d >> 8) & 32'h7);
        m_irq[p] = int'((d >> 28) & 32'hF);
      end
    end
  endtask

  // input history, sampled at every rising edge out of reset
  always @(posedge clk) begin
    if (!rst_n) hist.delete();
    else begin
      hist.push_back(pad_in);
      if (hist.size() > 4) void'(hist.pop_front());
    end
  end

  // per-clock comparison of pad outputs against the model
  always @(negedge clk) begin : mon
    logic [NP-1:0]   eoe, eout;
    logic [4*NP-1:0] eirq;
    logic [3*NP-1:0] etrig;
    if (rst_n && !done) begin
      for (int p = 0; p < NP; p++) begin
        eoe[p]  = fitted(p) && (m_mode[p] == 0 || m_mode[p] == 1);
        eout[p] = fitted(p) && (m_tx[p] == 1);
        eirq[4*p +: 4]  = fitted(p) ? 4'(m_irq[p]) : 4'd0;
        etrig[3*p +: 3] = fitted(p) ? 3'(m_trig[p]) : 3'd0;
      end
      check(pad_oe === eoe, "R7 pad_oe per clock", 256'(pad_oe), 256'(eoe));
      check(pad_out === eout, "R8 pad_out per clock", 256'(pad_out), 256'(eout));
      check(pad_irq_sel === eirq, "R11 pad_irq_sel per clock", 256'(pad_irq_sel), 256'(eirq));
      check(pad_irq_trig === etrig, "R11 pad_irq_trig per clock", 256'(pad_irq_trig), 256'(etrig));
      if (!bus_en) check(bus_err === 1'b0, "R2 idle err", 256'(bus_err), 256'd0);
    end
  end

  initial begin : wdog
    #(200000 * 5);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [31:0]   got;
    logic [NP-1:0] pat;
    bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0; pad_in = '0;
    model_reset();
    repeat (3) @(posedge clk);
    #1;
    check(pad_oe === '0, "R6 reset pad_oe", 256'(pad_oe), 256'd0);
    check(pad_out === '0, "R6 reset pad_out", 256'(pad_out), 256'd0);
    check(pad_irq_sel === '0 && pad_irq_trig === '0, "R6 reset irq fields",
          256'(pad_irq_sel), 256'd0);
    @(posedge clk); #1 rst_n = 1'b1;

    rd(pad_addr(0, 0, 0), "R6 reset word0 via model", got);
    check(got === 32'h0000_0300, "R6 reset word0 value", 256'(got), 256'h300);
    rd(pad_addr(3, 11, 1), "R6 reset word1", got);

    // R1/R4: sweep every fitted pad with reserved bits set, then read back
    for (int p = 0; p < NP; p++) begin
      if (fitted(p))
        wr(pad_addr(p / 15, p % 15, 0),
           (32'(p % 16) << 28) | 32'h0FFF_F8FD | (32'(p % 4) << 8) | (32'(p & 1) << 1));
    end
    for (int p = 0; p < NP; p++) begin
      if (fitted(p)) rd(pad_addr(p / 15, p % 15, 0), "R1 R4 readback word0", got);
    end
    rd(pad_addr(1, 14, 0), "R1 last slot of full group", got);
    check(got[31:28] === 4'd13 && got[10:8] === 3'd1, "R1 R4 field placement",
          256'(got), 256'hD000_0100);

    // R5/R11: second word
    wr(pad_addr(2, 7, 1), 32'hFFFF_FFFF);
    rd(pad_addr(2, 7, 1), "R5 word1 readback", got);
    check(got === 32'h0000_00F7, "R5 word1 value", 256'(got), 256'hF7);
    check(pad_irq_trig[3*37 +: 3] === 3'd7, "R11 trig export", 256'(pad_irq_trig[3*37 +: 3]), 256'd7);
    wr(pad_addr(0, 3, 1), 32'h0000_0025);
    rd(pad_addr(0, 3, 1), "R5 word1 partial", got);

    // R2/R3: error addresses
    rd(pad_addr(0, 9, 0), "R2 unfitted slot read", got);
    rd(pad_addr(2, 8, 1), "R2 unfitted slot word1", got);
    rd(pad_addr(1, 15, 0), "R2 slot 15 read", got);
    rd(pad_addr(4, 0, 0), "R2 group beyond count", got);
    rd('h4000, "R2 below base", got);
    rd('h4402, "R2 misaligned", got);
    rd('hFFFC, "R2 top of space", got);
    wr(pad_addr(1, 15, 0), 32'hF000_0102);
    rd(pad_addr(2, 0, 0), "R3 slot 15 write did not alias", got);
    wr(pad_addr(0, 9, 0), 32'hF000_0002);
    wr(pad_addr(2, 8, 1), 32'hFFFF_FFFF);
    wr('h4406, 32'hF000_0002);
    rd(pad_addr(0, 8, 0), "R3 neighbour unchanged", got);
    check(pad_oe[9] === 1'b0 && pad_out[9] === 1'b0, "R3 R8 unfitted pad quiet",
          256'({pad_oe[9], pad_out[9]}), 256'd0);

    // R7/R12: each mode with output level 1 on pad 16
    for (int m = 0; m < 8; m++) begin
      wr(pad_addr(1, 1, 0), (32'(m) << 8) | 32'h2);
      check(pad_oe[16] === (m < 2), "R7 R12 oe after mode write", 256'(pad_oe[16]), 256'(m < 2));
      check(pad_out[16] === 1'b1, "R8 R12 out follows level bit", 256'(pad_out[16]), 256'd1);
    end

    // R9: two-edge input latency on pad 17
    wr(pad_addr(1, 2, 0), 32'h0000_0200);
    wr(pad_addr(1, 2, 1), 32'h0000_0000);
    @(posedge clk); #1 pad_in[17] = 1'b1;
    rd(pad_addr(1, 2, 0), "R9 one edge later", got);
    check(got[0] === 1'b0, "R9 not yet visible", 256'(got[0]), 256'd0);
    rd(pad_addr(1, 2, 0), "R9 two edges later", got);
    check(got[0] === 1'b1, "R9 visible after two edges", 256'(got[0]), 256'd1);
    wr(pad_addr(1, 2, 0), 32'h0000_0100);
    rd(pad_addr(1, 2, 0), "R9 hidden in output mode", got);
    check(got[0] === 1'b0, "R9 gated bit0", 256'(got[0]), 256'd0);

    // R10: inversion
    wr(pad_addr(1, 2, 0), 32'h0000_0200);
    wr(pad_addr(1, 2, 1), 32'h0000_0040);
    rd(pad_addr(1, 2, 0), "R10 inverted high", got);
    check(got[0] === 1'b0, "R10 inverted bit0", 256'(got[0]), 256'd0);
    @(posedge clk); #1 pad_in[17] = 1'b0;
    repeat (2) @(posedge clk);
    rd(pad_addr(1, 2, 0), "R10 inverted low", got);
    check(got[0] === 1'b1, "R10 inverted low bit0", 256'(got[0]), 256'd1);
    wr(pad_addr(1, 2, 1), 32'h0000_00B0);
    rd(pad_addr(1, 2, 0), "R10 other inversion bits no effect", got);
    check(got[0] === 1'b0, "R10 no inversion", 256'(got[0]), 256'd0);

    // R9/R12: moving input pattern while reading many pads
    pat = 60'h5A3_C96E_1F04_B72D;
    for (int i = 0; i < 40; i++) begin
      int p;
      @(posedge clk); #1 pad_in = pat;
      pat = {pat[NP-2:0], ~(pat[NP-1] ^ pat[NP-6])};
      p = (i * 7) % NP;
      while (!fitted(p)) p = (p + 1) % NP;
      rd(pad_addr(p / 15, p % 15, 0), "R9 R12 random input read", got);
    end

    repeat (2) @(posedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule